// File: doc/BRIEF.md
# Mixed-Length Instruction Predecoder

This block sits between a 32-bit instruction fetch port and the decode stage of a core whose program stream mixes 32-bit and 64-bit instructions. The two lowest bits of each instruction's first word pick its kind. A value of 11 marks an ordinary 32-bit instruction. A value of 10 marks a 64-bit instruction with two operations that issue in parallel. A value of 00 marks a 64-bit single-issue instruction that carries a full 32-bit immediate. A value of 01 is not a legal format.

Fetched words enter with their program counter under a valid/ready handshake. When a word opens a 64-bit instruction, the block holds it until the second word arrives, however many cycles apart the two words come. It then presents the whole instruction as one registered output. The output carries the format tag, the address of the first word and the length in bytes. For dual-issue instructions it also carries the operation for each of the two issue slots. A flush input, raised for example on a taken branch, drops any half-built instruction and any instruction waiting at the output. Backpressure from decode stops the block from taking new fetch words.

Top module: `mlx_predecode`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid` is 0, and `in_ready` is 1 once reset has gone high. No half instruction is held after reset.
- R2: A first word whose bits [1:0] are 11 is emitted alone with `out_fmt`=11, `out_len`=4, `out_lo` equal to the word, `out_hi`=0, `out_illegal`=0, and `out_pc` equal to that word's PC.
- R3: A first word whose bits [1:0] are 10 is joined with the next accepted word into one output with `out_fmt`=10 and `out_len`=8. `out_slot_a` (compute/control operation) is the first word, `out_slot_b` (load/store or move operation) is the second word, and `out_pc` is the first word's PC.
- R4: A first word whose bits [1:0] are 00 is joined with the next accepted word into one output with `out_fmt`=00 and `out_len`=8. `out_lo` is the first word and `out_hi` (the immediate) is the second. Both slot outputs are 0 for every format other than 10.
- R5: A first word whose bits [1:0] are 01 is emitted alone with `out_illegal`=1, `out_fmt`=01, `out_len`=4 and `out_lo` equal to the word. `out_illegal` is 0 for all other formats.
- R6: While only the first word of a 64-bit instruction has been accepted, `out_valid` stays 0, no matter how many idle cycles pass before the second word.
- R7: The format comes only from the first word. The low bits of the second word of a 64-bit instruction are ignored, so a second word ending in 01 does not raise `out_illegal`.
- R8: While `flush` is high, `in_ready` is 0. One cycle after `flush`, `out_valid` is 0 and any held first half is gone, so the next accepted word starts a new instruction.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output holds its value. Across any pattern of stalls, each instruction is emitted exactly once and in program order.
- R10: A word that completes an instruction, accepted at one clock edge, shows up with `out_valid`=1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the held half and the pending output |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Block takes the fetch word this cycle |
| in_word | input | WORD_W | Fetched instruction word |
| in_pc | input | PC_W | Address of the fetched word |
| out_valid | output | 1 | Instruction present at the output |
| out_ready | input | 1 | Decode accepts the instruction |
| out_fmt | output | 2 | Format tag taken from the first word |
| out_len | output | LEN_W | Instruction length in bytes (4 or 8) |
| out_pc | output | PC_W | Address of the instruction's first word |
| out_lo | output | WORD_W | First word |
| out_hi | output | WORD_W | Second word, 0 for 32-bit instructions |
| out_illegal | output | 1 | Format 01 seen |
| out_slot_a | output | WORD_W | Compute/control operation of a dual-issue instruction |
| out_slot_b | output | WORD_W | Memory/move operation of a dual-issue instruction |

## Verification
The state most likely to go wrong is the flag that marks a held first half. If that flag is stuck set, the next fresh word is taken as an upper half. The very next output then shows the wrong length and the older PC, or no output appears at all. If the flag is lost, a 64-bit instruction comes out as two short ones, and the second of them carries a random format. A broken stall or flush path shows at once: an output changes or drops during a stall, or a word is accepted while `flush` is high. Random streams with random gaps and stalls are compared one output at a time against an expected list built from the generated program. Any loss, duplicate or reordering is therefore flagged at the first output it touches.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

   typedef enum logic [1:0] {
      FMT_LONG = 2'b00,
      FMT_BAD  = 2'b01,
      FMT_DUAL = 2'b10,
      FMT_STD  = 2'b11
   } fmt_e;

   function automatic logic fmt_is_wide(fmt_e f);
      return (f == FMT_DUAL) || (f == FMT_LONG);
   endfunction

endpackage

// File: rtl/mlx_fmt_classify.sv
module mlx_fmt_classify
   import mlx_pkg::*;
(
   input  logic [1:0] fmt_bits,
   output fmt_e       fmt,
   output logic       wide,
   output logic       bad
);
   always_comb begin
      fmt  = fmt_e'(fmt_bits);
      wide = fmt_is_wide(fmt);
      bad  = (fmt == FMT_BAD);
   end
endmodule

// File: rtl/mlx_half_buf.sv
module mlx_half_buf
   import mlx_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              consume,
   input  logic [WORD_W-1:0] word_in,
   input  logic [PC_W-1:0]   pc_in,
   input  fmt_e              fmt_in,
   output logic              pend,
   output logic [WORD_W-1:0] word,
   output logic [PC_W-1:0]   pc,
   output fmt_e              fmt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         word <= '0;
         pc   <= '0;
         fmt  <= FMT_STD;
      end else if (clr) begin
         pend <= 1'b0;
      end else if (load) begin
         pend <= 1'b1;
         word <= word_in;
         pc   <= pc_in;
         fmt  <= fmt_in;
      end else if (consume) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/mlx_out_stage.sv
module mlx_out_stage
   import mlx_pkg::*;
#(
   parameter int WORD_W          = 32,
   parameter int PC_W            = 32,
   parameter int LEN_W           = 4,
   parameter bit ZERO_IDLE_SLOTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              pop,
   input  fmt_e              fmt_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [WORD_W-1:0] lo_in,
   input  logic [WORD_W-1:0] hi_in,
   input  logic              bad_in,
   output logic              valid,
   output fmt_e              fmt,
   output logic [LEN_W-1:0]  len,
   output logic [PC_W-1:0]   pc,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi,
   output logic              bad,
   output logic [WORD_W-1:0] slot_a,
   output logic [WORD_W-1:0] slot_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         fmt   <= FMT_STD;
         len   <= '0;
         pc    <= '0;
         lo    <= '0;
         hi    <= '0;
         bad   <= 1'b0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         fmt   <= fmt_in;
         len   <= len_in;
         pc    <= pc_in;
         lo    <= lo_in;
         hi    <= hi_in;
         bad   <= bad_in;
      end else if (pop) begin
         valid <= 1'b0;
      end
   end

   generate
      if (ZERO_IDLE_SLOTS) begin : g_gated_slots
         always_comb begin
            slot_a = (fmt == FMT_DUAL) ? lo : '0;
            slot_b = (fmt == FMT_DUAL) ? hi : '0;
         end
      end else begin : g_raw_slots
         always_comb begin
            slot_a = lo;
            slot_b = hi;
         end
      end
   endgenerate
endmodule

// File: rtl/mlx_predecode.sv
module mlx_predecode
   import mlx_pkg::*;
#(
   parameter int WORD_W          = 32,
   parameter int PC_W            = 32,
   parameter bit ZERO_IDLE_SLOTS = 1'b1,
   localparam int WORD_BYTES     = WORD_W / 8,
   localparam int LEN_W          = $clog2(2 * WORD_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic [PC_W-1:0]   in_pc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_fmt,
   output logic [LEN_W-1:0]  out_len,
   output logic [PC_W-1:0]   out_pc,
   output logic [WORD_W-1:0] out_lo,
   output logic [WORD_W-1:0] out_hi,
   output logic              out_illegal,
   output logic [WORD_W-1:0] out_slot_a,
   output logic [WORD_W-1:0] out_slot_b
);
   localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(WORD_BYTES);
   localparam logic [LEN_W-1:0] LEN_WIDE  = LEN_W'(2 * WORD_BYTES);

   generate
      if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_word
         $fatal(1, "WORD_W must be a whole number of bytes");
      end
      if (PC_W < 2) begin : g_bad_pc
         $fatal(1, "PC_W must be at least 2");
      end
   endgenerate

   fmt_e              in_fmt;
   logic              in_wide;
   logic              in_bad;
   logic              accept;
   logic              half_pend;
   logic [WORD_W-1:0] half_word;
   logic [PC_W-1:0]   half_pc;
   fmt_e              half_fmt;
   logic              out_load;
   fmt_e              nxt_fmt;
   logic [LEN_W-1:0]  nxt_len;
   logic [PC_W-1:0]   nxt_pc;
   logic [WORD_W-1:0] nxt_lo;
   logic [WORD_W-1:0] nxt_hi;
   logic              nxt_bad;
   fmt_e              st_fmt;

   mlx_fmt_classify u_cls (
      .fmt_bits (in_word[1:0]),
      .fmt      (in_fmt),
      .wide     (in_wide),
      .bad      (in_bad)
   );

   assign in_ready = !flush && (!out_valid || out_ready);
   assign accept   = in_valid && in_ready;
   assign out_load = accept && (half_pend || !in_wide);

   mlx_half_buf #(.WORD_W(WORD_W), .PC_W(PC_W)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush),
      .load    (accept && !half_pend && in_wide),
      .consume (accept && half_pend),
      .word_in (in_word),
      .pc_in   (in_pc),
      .fmt_in  (in_fmt),
      .pend    (half_pend),
      .word    (half_word),
      .pc      (half_pc),
      .fmt     (half_fmt)
   );

   always_comb begin
      if (half_pend) begin
         nxt_fmt = half_fmt;
         nxt_len = LEN_WIDE;
         nxt_pc  = half_pc;
         nxt_lo  = half_word;
         nxt_hi  = in_word;
         nxt_bad = 1'b0;
      end else begin
         nxt_fmt = in_fmt;
         nxt_len = LEN_SHORT;
         nxt_pc  = in_pc;
         nxt_lo  = in_word;
         nxt_hi  = '0;
         nxt_bad = in_bad;
      end
   end

   mlx_out_stage #(
      .WORD_W          (WORD_W),
      .PC_W            (PC_W),
      .LEN_W           (LEN_W),
      .ZERO_IDLE_SLOTS (ZERO_IDLE_SLOTS)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (flush),
      .load   (out_load),
      .pop    (out_valid && out_ready),
      .fmt_in (nxt_fmt),
      .len_in (nxt_len),
      .pc_in  (nxt_pc),
      .lo_in  (nxt_lo),
      .hi_in  (nxt_hi),
      .bad_in (nxt_bad),
      .valid  (out_valid),
      .fmt    (st_fmt),
      .len    (out_len),
      .pc     (out_pc),
      .lo     (out_lo),
      .hi     (out_hi),
      .bad    (out_illegal),
      .slot_a (out_slot_a),
      .slot_b (out_slot_b)
   );

   assign out_fmt = st_fmt;
endmodule

// File: rtl/mlx_predecode_chk.sv
module mlx_predecode_chk #(
   parameter int WORD_W          = 32,
   parameter int PC_W            = 32,
   parameter bit ZERO_IDLE_SLOTS = 1'b1,
   localparam int WORD_BYTES     = WORD_W / 8,
   localparam int LEN_W          = $clog2(2 * WORD_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_fmt,
   input logic [LEN_W-1:0]  out_len,
   input logic [PC_W-1:0]   out_pc,
   input logic [WORD_W-1:0] out_lo,
   input logic [WORD_W-1:0] out_hi,
   input logic              out_illegal,
   input logic [WORD_W-1:0] out_slot_a,
   input logic [WORD_W-1:0] out_slot_b
);
   localparam logic [LEN_W-1:0] LEN_WIDE = LEN_W'(2 * WORD_BYTES);

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);  // R1

   AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);  // R9

   AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=>
         (out_valid && $stable(out_pc) && $stable(out_lo) && $stable(out_hi)
          && $stable(out_fmt) && $stable(out_len)));  // R9

   AST_WIDE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_len == LEN_WIDE) == (out_fmt == 2'b10 || out_fmt == 2'b00)));  // R3

   AST_ILLEGAL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_illegal == (out_fmt == 2'b01)));  // R5

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);  // R8

   AST_FLUSH_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);  // R8

   generate
      if (ZERO_IDLE_SLOTS) begin : g_zero
         AST_SLOT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_fmt != 2'b10) |-> (out_slot_a == '0 && out_slot_b == '0));  // R4
      end else begin : g_raw
         AST_SLOT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_slot_a == out_lo && out_slot_b == out_hi));  // R3
      end
   endgenerate
endmodule

bind mlx_predecode mlx_predecode_chk #(
   .WORD_W          (WORD_W),
   .PC_W            (PC_W),
   .ZERO_IDLE_SLOTS (ZERO_IDLE_SLOTS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_fmt     (out_fmt),
   .out_len     (out_len),
   .out_pc      (out_pc),
   .out_lo      (out_lo),
   .out_hi      (out_hi),
   .out_illegal (out_illegal),
   .out_slot_a  (out_slot_a),
   .out_slot_b  (out_slot_b)
);

// File: tb/tb_mlx_predecode.sv
module tb_mlx_predecode;
   localparam int N_INSTR = 300;
   localparam int MAXW    = 2 * N_INSTR;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic [31:0] in_pc = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [1:0]  out_fmt;
   logic [3:0]  out_len;
   logic [31:0] out_pc, out_lo, out_hi, out_slot_a, out_slot_b;
   logic        out_illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] words [MAXW];
   logic [1:0]  e_fmt [N_INSTR];
   logic [3:0]  e_len [N_INSTR];
   logic [31:0] e_pc  [N_INSTR];
   logic [31:0] e_lo  [N_INSTR];
   logic [31:0] e_hi  [N_INSTR];
   int nw = 0;

   always #5 clk = ~clk;

   mlx_predecode dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_pc(in_pc),
      .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt),
      .out_len(out_len), .out_pc(out_pc), .out_lo(out_lo), .out_hi(out_hi),
      .out_illegal(out_illegal), .out_slot_a(out_slot_a), .out_slot_b(out_slot_b)
   );

   task automatic chk(input bit ok, input string req, input logic [166:0] act,
                      input logic [166:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [166:0] pack_exp(input logic [1:0] f, input logic [3:0] l,
         input logic [31:0] p, input logic [31:0] lo, input logic [31:0] hi);
      logic ill = (f == 2'b01);
      logic [31:0] sa = (f == 2'b10) ? lo : 32'h0;
      logic [31:0] sb = (f == 2'b10) ? hi : 32'h0;
      return {f, l, p, lo, hi, ill, sa, sb};
   endfunction

   function automatic logic [166:0] pack_act();
      return {out_fmt, out_len, out_pc, out_lo, out_hi, out_illegal, out_slot_a, out_slot_b};
   endfunction

   function automatic string req_of(input logic [1:0] f);
      case (f)
         2'b11:   return "R2";
         2'b10:   return "R3";
         2'b00:   return "R4";
         default: return "R5";
      endcase
   endfunction

   // one cycle: drive at the falling edge, let logic settle
   task automatic cyc(input bit v, input logic [31:0] w, input logic [31:0] p,
                      input bit rdy, input bit fl);
      @(negedge clk);
      in_valid  = v;
      in_word   = w;
      in_pc     = p;
      out_ready = rdy;
      flush     = fl;
      #1;
   endtask

   task automatic expect_out(input string req, input logic [1:0] f, input logic [3:0] l,
         input logic [31:0] p, input logic [31:0] lo, input logic [31:0] hi);
      logic [166:0] e = pack_exp(f, l, p, lo, hi);
      chk(out_valid && pack_act() == e, req, {out_valid, pack_act()}, {1'b1, e});
   endtask

   initial begin
      void'($urandom(32'd20240611));

      // R1: reset
      repeat (3) @(negedge clk);
      chk(!out_valid, "R1", 167'(out_valid), 167'(0));
      rst_n = 1'b1;
      cyc(0, 0, 0, 1, 0);
      chk(!out_valid && in_ready, "R1", 167'({out_valid, in_ready}), 167'(2'b01));

      // R2, R10, R9: plain word then stall
      cyc(1, 32'h1234_5673, 32'h100, 1, 0);
      cyc(0, 0, 0, 0, 0);
      expect_out("R10 R2", 2'b11, 4'd4, 32'h100, 32'h1234_5673, 32'h0);
      cyc(1, 32'h0BAD_0003, 32'h104, 0, 0);
      chk(!in_ready, "R9", 167'(in_ready), 167'(0));
      cyc(0, 0, 0, 0, 0);
      expect_out("R9", 2'b11, 4'd4, 32'h100, 32'h1234_5673, 32'h0);
      cyc(0, 0, 0, 1, 0);
      cyc(0, 0, 0, 1, 0);
      chk(!out_valid, "R9", 167'(out_valid), 167'(0));

      // R6, R7, R3: dual-issue split by idle cycles, second word ends in 01
      cyc(1, 32'hABCD_0012, 32'h200, 1, 0);
      cyc(0, 0, 0, 1, 0);
      chk(!out_valid, "R6", 167'(out_valid), 167'(0));
      cyc(0, 0, 0, 1, 0);
      chk(!out_valid, "R6", 167'(out_valid), 167'(0));
      cyc(1, 32'h5555_0001, 32'h204, 1, 0);
      cyc(0, 0, 0, 1, 0);
      expect_out("R3 R7", 2'b10, 4'd8, 32'h200, 32'hABCD_0012, 32'h5555_0001);
      cyc(0, 0, 0, 1, 0);
      chk(!out_valid, "R9", 167'(out_valid), 167'(0));

      // R5: illegal format
      cyc(1, 32'h0000_0F01, 32'h300, 1, 0);
      cyc(0, 0, 0, 1, 0);
      expect_out("R5", 2'b01, 4'd4, 32'h300, 32'h0000_0F01, 32'h0);

      // R4: long immediate, back to back
      cyc(1, 32'h0000_0A00, 32'h400, 1, 0);
      cyc(1, 32'hDEAD_BEEF, 32'h404, 1, 0);
      cyc(0, 0, 0, 1, 0);
      expect_out("R4", 2'b00, 4'd8, 32'h400, 32'h0000_0A00, 32'hDEAD_BEEF);

      // R8: flush drops a held first half
      cyc(1, 32'h0000_0A00, 32'h500, 1, 0);
      cyc(0, 0, 0, 1, 1);
      cyc(1, 32'h7777_0003, 32'h600, 1, 0);
      cyc(0, 0, 0, 1, 0);
      expect_out("R8", 2'b11, 4'd4, 32'h600, 32'h7777_0003, 32'h0);

      // R8: flush drops a stalled output
      cyc(1, 32'h1111_0003, 32'h700, 0, 0);
      cyc(0, 0, 0, 0, 0);
      chk(out_valid, "R8", 167'(out_valid), 167'(1));
      cyc(1, 32'h2222_0003, 32'h704, 0, 1);
      chk(!in_ready, "R8", 167'(in_ready), 167'(0));
      cyc(0, 0, 0, 0, 0);
      chk(!out_valid, "R8", 167'(out_valid), 167'(0));

      // random program with gaps and stalls
      begin
         int ne = 0;
         int wi = 0;
         int oi = 0;
         for (int i = 0; i < N_INSTR; i++) begin
            int r = int'($urandom % 8);
            logic [1:0] f = (r < 3) ? 2'b11 : (r < 5) ? 2'b10 : (r < 7) ? 2'b00 : 2'b01;
            logic [31:0] lo = $urandom;
            logic [31:0] hi = $urandom;
            lo[1:0] = f;
            words[nw] = lo;
            e_fmt[ne] = f;
            e_pc[ne]  = 32'h1000 + 32'(4 * nw);
            e_lo[ne]  = lo;
            nw++;
            if (f == 2'b10 || f == 2'b00) begin
               words[nw] = hi;
               e_hi[ne]  = hi;
               e_len[ne] = 4'd8;
               nw++;
            end else begin
               e_hi[ne]  = 32'h0;
               e_len[ne] = 4'd4;
            end
            ne++;
         end
         while (oi < ne) begin
            @(negedge clk);
            in_valid  = (wi < nw) && ($urandom % 4 != 0);
            in_word   = (wi < nw) ? words[wi] : 32'h0;
            in_pc     = 32'h1000 + 32'(4 * wi);
            out_ready = ($urandom % 3 != 0);
            flush     = 1'b0;
            #1;
            if (out_valid && out_ready) begin
               expect_out(req_of(e_fmt[oi]), e_fmt[oi], e_len[oi], e_pc[oi], e_lo[oi], e_hi[oi]);
               oi++;
            end
            if (in_valid && in_ready) wi++;
         end
         cyc(0, 0, 0, 1, 0);
         cyc(0, 0, 0, 1, 0);
         chk(!out_valid && wi == nw, "R9", 167'({out_valid, 32'(wi)}), 167'({1'b0, 32'(nw)}));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R9: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule